// File: doc/BRIEF.md
# Two-Wire EEPROM Target Protocol Engine

This block is the bus-facing half of a byte-addressed serial memory. It oversamples the clock and data lines of a two-wire bus with a fast system clock. It recognises start and stop conditions and decodes the first byte of each command, which carries a fixed preamble, chip-select bits and a direction bit. It then either takes a word address and turns each following data byte into a write request, or streams bytes out of the array. Each byte it accepts is acknowledged by pulling the open-drain data line low for one bus clock. The physical pad, input filtering and the nonvolatile storage sit outside the block.

The parameter `ADDR_W` (9, 10 or 11) sets the array size to 512, 1024 or 2048 bytes. The three chip-select positions of the first byte, at bits 3, 2 and 1, are compared against the strap pins from bit 3 downward, 2, 1 or 0 of them for widths 9, 10 and 11. The positions that are not compared carry the high word-address bits. A random read is a write of the word address, then a repeated start with a read command. While the external programming cycle runs (`prog_busy` high), the engine ignores the bus completely.

Write requests leave on a valid/ready port. `wr_valid` rises with `wr_addr` and `wr_data`, and all three hold steady until a cycle with `wr_ready` high. The bus cannot be stalled. If a further data byte completes while a request is still waiting, that byte is refused with a missing acknowledge and the rest of the transfer is ignored. Read data is fetched through `rd_addr`/`rd_data` with a zero-latency lookup.

Top module: `twi_eeprom_target`

## Requirements
- R1: After reset, `sda_pull`, `wr_valid` and `prog_start` are all low.
- R2: SDA falling while SCL is high (start) restarts reception of a command byte from any state, including the middle of a byte, and releases SDA. SDA rising while SCL is high (stop) returns the engine to idle.
- R3: A command byte whose four most significant bits are not 1010 gets no acknowledge, and the engine stays silent until the next start.
- R4: Command bits 3, 2, 1 are compared with `cs_pins[2]`, `cs_pins[1]`, `cs_pins[0]`, only the first 11-`ADDR_W` of them. The rest supply word-address bits `ADDR_W`-1 down to 8, highest bit first. A mismatch gets no acknowledge.
- R5: For each accepted byte, the engine pulls SDA low from the SCL fall after the eighth data bit to the SCL fall after the ninth clock. It never pulls SDA during the eight data bits of a received byte.
- R6: Command bit 0 low selects write. The next byte sets the low eight address bits. Each further byte issues one write request at the current address, and the address then increments, wrapping from the top of the array to 0.
- R7: `wr_valid`, `wr_addr` and `wr_data` stay stable until `wr_ready`. A data byte that completes while a request is still waiting gets no acknowledge.
- R8: A stop that ends a write with at least one acknowledged data byte since the last start gives a one-cycle `prog_start` pulse. Any other stop gives none.
- R9: Command bit 0 high selects read. Bytes at the current address go out MSB first, with each bit changed on SCL falls. The address increments after every byte and wraps at the top of the array.
- R10: During a read, a low level on the ninth clock continues with the next byte. A high level ends the read, and SDA is left released until the next start.
- R11: The word address survives a repeated start, so a dummy write followed by a read command reads from the written address, with the high bits taken from the read command.
- R12: While `prog_busy` is high, the engine acknowledges nothing, issues no write request and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved wired-AND) |
| cs_pins | input | 3 | Strapped chip-select pins, bit 2 highest |
| prog_busy | input | 1 | Programming cycle in progress; bus ignored |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA |
| rd_addr | output | ADDR_W | Current read address |
| rd_data | input | 8 | Array byte at `rd_addr` |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Page buffer accepts the request |
| wr_addr | output | ADDR_W | Write request address |
| wr_data | output | 8 | Write request data |
| prog_start | output | 1 | One-cycle pulse: programming may begin |

## Verification
The hardest case to reach is a data byte completing while the previous write request is still waiting. The page buffer normally takes requests at once, so the bench holds `wr_ready` low over two data bytes to get there. It then checks that the second byte gets no acknowledge while the first request keeps its address and data. Other cases that need deliberate stimulus are the address wrap, a start placed four bits into a command byte, and a read ended by a missing acknowledge.

// File: rtl/twi_tgt_pkg.sv
package twi_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_ACK, ST_TX, ST_MACK, ST_HALT
  } tgt_st_t;
  localparam logic [3:0] DEV_PREAMBLE = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);
  localparam int TOP = STAGES - 1;
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[TOP-1:0], scl_i};
      sda_sr <= {sda_sr[TOP-1:0], sda_i};
      scl_q  <= scl_sr[TOP];
      sda_q  <= sda_sr[TOP];
    end
  end

  assign sda_bit   = sda_sr[TOP];
  assign scl_rise  = scl_sr[TOP] & ~scl_q;
  assign scl_fall  = ~scl_sr[TOP] & scl_q;
  assign start_det = scl_sr[TOP] & scl_q & sda_q & ~sda_sr[TOP];
  assign stop_det  = scl_sr[TOP] & scl_q & ~sda_q & sda_sr[TOP];
endmodule

// File: rtl/twi_devsel.sv
module twi_devsel
  import twi_tgt_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [7:0]        dev_byte,
  input  logic [2:0]        cs_pins,
  output logic              hit,
  output logic [ADDR_W-9:0] hi_bits
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int CMP_N = 3 - HI_W;

  logic [2:0] eq;
  logic unused_bits;

  for (genvar i = 0; i < 3; i++) begin : g_cmp
    if (i < CMP_N) begin : g_on
      assign eq[i] = (dev_byte[3-i] == cs_pins[2-i]);
    end else begin : g_off
      assign eq[i] = 1'b1;
    end
  end

  for (genvar j = 0; j < HI_W; j++) begin : g_hi
    assign hi_bits[j] = dev_byte[1+j];
  end

  assign hit = (dev_byte[7:4] == DEV_PREAMBLE) && (&eq);
  assign unused_bits = ^{dev_byte[0], cs_pins};
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_tgt_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_bit,
  input  logic              prog_busy,
  input  logic [2:0]        cs_pins,
  input  logic [7:0]        rd_data,
  input  logic              wr_ready,
  output logic              sda_pull,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              prog_start
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] HOST_ACK = 4'd9;

  tgt_st_t st, ret_st;
  logic [3:0]        cnt;
  logic [7:0]        sh;
  logic [ADDR_W-1:0] addr;
  logic              wrote;
  logic              hit;
  logic [ADDR_W-9:0] hi_bits;

  twi_devsel #(.ADDR_W(ADDR_W)) u_devsel (
    .dev_byte(sh), .cs_pins(cs_pins), .hit(hit), .hi_bits(hi_bits)
  );

  assign rd_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ret_st <= ST_IDLE; cnt <= '0; sh <= '0; addr <= '0;
      wrote <= 1'b0; sda_pull <= 1'b0; wr_valid <= 1'b0; wr_addr <= '0;
      wr_data <= '0; prog_start <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (prog_busy) begin
        st <= ST_IDLE; sda_pull <= 1'b0; wrote <= 1'b0;
      end else if (start_det) begin
        st <= ST_DEV; cnt <= '0; sda_pull <= 1'b0; wrote <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_pull <= 1'b0; prog_start <= wrote; wrote <= 1'b0;
      end else begin
        case (st)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && cnt != LAST_BIT) begin
              sh  <= {sh[6:0], sda_bit};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              cnt <= '0;
              if (st == ST_DEV) begin
                if (hit) begin
                  sda_pull <= 1'b1;
                  addr[ADDR_W-1:8] <= hi_bits;
                  ret_st <= sh[0] ? ST_TX : ST_WADDR;
                  st <= ST_ACK;
                end else begin
                  st <= ST_HALT;
                end
              end else if (st == ST_WADDR) begin
                addr[7:0] <= sh;
                sda_pull <= 1'b1;
                ret_st <= ST_WDATA;
                st <= ST_ACK;
              end else if (wr_valid && !wr_ready) begin
                st <= ST_HALT;
              end else begin
                wr_valid <= 1'b1;
                wr_addr  <= addr;
                wr_data  <= sh;
                addr     <= addr + 1'b1;
                wrote    <= 1'b1;
                sda_pull <= 1'b1;
                ret_st   <= ST_WDATA;
                st       <= ST_ACK;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            cnt <= '0;
            st  <= ret_st;
            if (ret_st == ST_TX) begin
              sh <= rd_data;
              sda_pull <= ~rd_data[7];
            end else begin
              sda_pull <= 1'b0;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_pull <= 1'b0;
                addr <= addr + 1'b1;
                cnt <= '0;
                st <= ST_MACK;
              end else begin
                sh <= {sh[6:0], 1'b0};
                sda_pull <= ~sh[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_bit) st <= ST_HALT;
              else cnt <= HOST_ACK;
            end else if (scl_fall && cnt == HOST_ACK) begin
              sh <= rd_data;
              sda_pull <= ~rd_data[7];
              cnt <= '0;
              st <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: a waiting request keeps its payload
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R12: busy forces the data line free
  a_r12_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |=> !sda_pull);
  // R8: programming trigger lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  // R5: drive changes only follow a clock fall or a bus condition
  a_r5_pull_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det || prog_busy));
  // R2: a start always frees the line
  a_r2_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);
endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target #(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        cs_pins,
  input  logic              prog_busy,
  output logic              sda_pull,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              prog_start
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_bit;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_bit(sda_bit)
  );

  twi_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
    .prog_busy(prog_busy), .cs_pins(cs_pins), .rd_data(rd_data),
    .wr_ready(wr_ready), .sda_pull(sda_pull), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_start(prog_start)
  );
endmodule

// File: tb/twi_eeprom_target_test.sv
module twi_eeprom_target_test;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl, sda_drv, prog_busy, wr_ready;
  logic [2:0] cs_pins;
  logic sda_pull, wr_valid, prog_start;
  logic sda_line;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [7:0] mem [DEPTH];
  logic [7:0] ref_mem [DEPTH];

  int n_chk = 0, n_bad = 0, commits = 0;
  int exp_q[$];
  int mon_got, mon_exp;
  bit done = 0;

  assign sda_line = sda_drv & ~sda_pull;
  assign rd_data = mem[rd_addr];

  twi_eeprom_target #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .cs_pins(cs_pins),
    .prog_busy(prog_busy), .sda_pull(sda_pull), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_start(prog_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // page buffer behaviour and reference comparison of write requests
  always @(posedge clk) if (wr_valid && wr_ready) mem[wr_addr] <= wr_data;
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      mon_got = {wr_addr, wr_data};
      if (exp_q.size() == 0) chk(0, "R6 unexpected write request", mon_got, 0);
      else begin
        mon_exp = exp_q.pop_front();
        chk(mon_got == mon_exp, "R6 write request addr/data", mon_got, mon_exp);
      end
    end
    if (rst_n && prog_start) commits++;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_drv = b; wt(10);
    scl = 1'b1; wt(10);
    s = sda_line; wt(10);
    scl = 1'b0; wt(10);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wt(10);
    scl = 1'b1; wt(10);
    sda_drv = 1'b0; wt(10);
    scl = 1'b0; wt(10);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wt(10);
    scl = 1'b1; wt(10);
    sda_drv = 1'b1; wt(10);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit chk_rel,
                           input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(b[i], s);
      if (b[i]) chk(s == 1'b1, "R5 no pull during data bits", s, 1);
    end
    clk_bit(1'b1, s);
    chk((s == 1'b0) == exp_ack, tag, !s, exp_ack);
    if (chk_rel) begin
      sda_drv = 1'b1; wt(1);
      chk(sda_line == 1'b1, "R5 release after ack clock", sda_line, 1);
    end
  endtask

  task automatic read_byte(output logic [7:0] d, input bit mack);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(mack ? 1'b0 : 1'b1, s);
  endtask

  task automatic expect_wr(input int a, input int d);
    exp_q.push_back((a << 8) | d);
    ref_mem[a] = d[7:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int c0;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'((i * 7) + 3);
      ref_mem[i] = 8'((i * 7) + 3);
    end
    rst_n = 1'b0; scl = 1'b1; sda_drv = 1'b1; prog_busy = 1'b0; wr_ready = 1'b1;
    cs_pins = 3'b101;
    wt(5); rst_n = 1'b1; wt(5);
    // R1
    chk(sda_pull == 1'b0, "R1 sda_pull after reset", sda_pull, 0);
    chk(wr_valid == 1'b0, "R1 wr_valid after reset", wr_valid, 0);
    chk(prog_start == 1'b0, "R1 prog_start after reset", prog_start, 0);

    // R3: wrong preamble
    bus_start(); send_byte(8'hB8, 0, 1, "R3 bad preamble not acked"); bus_stop();
    // R4: chip-select mismatch on cs_pins[1]
    bus_start(); send_byte(8'hAC, 0, 1, "R4 chip-select mismatch not acked"); bus_stop();

    // R6/R8: byte write, uncompared bit 1 = 0
    c0 = commits;
    bus_start();
    send_byte(8'hA8, 1, 1, "R4 matching command acked");
    send_byte(8'h10, 1, 1, "R6 word address acked");
    expect_wr(16'h010, 8'h5A);
    send_byte(8'h5A, 1, 1, "R5 data byte acked");
    bus_stop(); wt(5);
    chk(commits == c0 + 1, "R8 prog_start after write stop", commits - c0, 1);

    // R6: page write with address bit 8 from command, wrapping at top
    c0 = commits;
    bus_start();
    send_byte(8'hAA, 1, 1, "R4 command with high address bit acked");
    send_byte(8'hFE, 1, 1, "R6 word address acked");
    expect_wr(9'h1FE, 8'h11); send_byte(8'h11, 1, 1, "R6 page byte 0 acked");
    expect_wr(9'h1FF, 8'h22); send_byte(8'h22, 1, 1, "R6 page byte 1 acked");
    expect_wr(9'h000, 8'h33); send_byte(8'h33, 1, 1, "R6 page byte 2 acked after wrap");
    bus_stop(); wt(5);
    chk(commits == c0 + 1, "R8 prog_start after page write", commits - c0, 1);

    // R11/R9/R10: random read across the wrap
    c0 = commits;
    bus_start();
    send_byte(8'hAA, 1, 1, "R11 dummy write command acked");
    send_byte(8'hFE, 1, 1, "R11 dummy word address acked");
    bus_start();
    send_byte(8'hAB, 1, 0, "R11 read command acked");
    read_byte(d, 1); chk(d == ref_mem[9'h1FE], "R11 random read byte", d, ref_mem[9'h1FE]);
    read_byte(d, 1); chk(d == ref_mem[9'h1FF], "R9 sequential read byte", d, ref_mem[9'h1FF]);
    read_byte(d, 0); chk(d == ref_mem[9'h000], "R9 read wraps to zero", d, ref_mem[9'h000]);
    read_byte(d, 0); chk(d == 8'hFF, "R10 line released after host nack", d, 8'hFF);
    bus_stop(); wt(5);
    chk(commits == c0, "R8 no prog_start for read", commits - c0, 0);

    // R4/R11: current-address read, high bit taken from the read command
    bus_start();
    send_byte(8'hAB, 1, 0, "R11 current read command acked");
    read_byte(d, 0); chk(d == ref_mem[9'h101], "R4 high bit from read command", d, ref_mem[9'h101]);
    bus_stop();

    // R2: start in the middle of a command byte restarts reception
    bus_start();
    begin
      logic s;
      clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    end
    bus_start();
    send_byte(8'hA8, 1, 1, "R2 command after mid-byte start acked");
    send_byte(8'h20, 1, 1, "R2 word address acked");
    expect_wr(16'h020, 8'h77); send_byte(8'h77, 1, 1, "R2 data acked");
    bus_stop(); wt(5);

    // R7: back-pressure
    c0 = commits;
    wr_ready = 1'b0;
    bus_start();
    send_byte(8'hA8, 1, 1, "R7 command acked");
    send_byte(8'h30, 1, 1, "R7 word address acked");
    expect_wr(16'h030, 8'h44); send_byte(8'h44, 1, 1, "R7 first data acked");
    send_byte(8'h55, 0, 1, "R7 data refused while request waits");
    chk(wr_valid == 1'b1, "R7 request still valid", wr_valid, 1);
    chk(wr_addr == 9'h030, "R7 request addr held", wr_addr, 9'h030);
    chk(wr_data == 8'h44, "R7 request data held", wr_data, 8'h44);
    bus_stop(); wt(5);
    chk(commits == c0 + 1, "R8 prog_start after accepted byte", commits - c0, 1);
    wr_ready = 1'b1; wt(5);
    chk(exp_q.size() == 0, "R7 waiting request delivered", exp_q.size(), 0);

    // R12: busy ignores everything
    c0 = commits;
    prog_busy = 1'b1;
    bus_start();
    send_byte(8'hA8, 0, 1, "R12 command ignored while busy");
    send_byte(8'h40, 0, 1, "R12 address ignored while busy");
    send_byte(8'h99, 0, 1, "R12 data ignored while busy");
    bus_stop(); wt(5);
    chk(commits == c0, "R12 no prog_start while busy", commits - c0, 0);
    chk(wr_valid == 1'b0, "R12 no write request while busy", wr_valid, 0);
    prog_busy = 1'b0; wt(5);
    chk(exp_q.size() == 0, "R6 all expected writes seen", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule